// File: doc/BRIEF.md
# Burst Beat Lane Placer

This block turns one burst command into a train of bus beats for a wide data path. A command carries a start byte address, a burst kind, a beat size and a beat count. For every narrow payload beat that arrives, the block works out that beat's byte address and the bus-aligned address. It builds the byte-strobe mask and shifts the payload into the matching byte lanes. The beat then leaves on an output stream with a last flag on the final beat.

Commands, payload beats and output beats each use a valid/ready handshake. A beat moves only in a cycle where both valid and ready are high. Back-pressure on the output stalls the payload input in the same cycle: `pl_ready` is low whenever a beat is waiting and `bt_ready` is low. A command is taken only while the block is idle. The command error pin is a plain one-cycle status pulse.

Top module: `burst_lane_gen`

## Requirements
- R1: `bt_addr` is the beat's byte address rounded down to a multiple of the bus width in bytes (16 for the default 128-bit bus).
- R2: Burst code 0 (fixed) gives every beat the start address, so every beat has the same bus address and the same strobe. For example, size code 0 at 0x106 gives strobe 0x0040 on each beat.
- R3: Burst code 1 (incrementing) uses the start address for beat 0. Beat i then uses the start address rounded down to the beat size, plus i times the beat size. An unaligned first beat strobes only the lanes from the start byte up to the next beat-size boundary.
- R4: Burst code 2 (wrapping) steps like incrementing but stays inside a window whose size is beat count times beat size. After the top of the window, the address returns to the bottom of the same window.
- R5: Payload byte k (bits 8k+7..8k of `pl_data`) goes to lane a+k, where a is the beat's lane offset rounded down to the beat size. Only lanes at or above the beat's own byte address and below a plus the beat size are strobed. Every other data bit is zero.
- R6: Size code s means 2^s bytes per beat. The code equal to log2 of the bus width in bytes (4 by default) strobes all lanes, and an incrementing burst of that size advances the bus address by the full bus width on each beat.
- R7: A command produces `cmd_len`+1 beats, and `bt_last` is high only on the final one.
- R8: A command with burst code 3, or with a size code above log2 of the bus width in bytes, is accepted but produces no beats. `cmd_err` is high for the one cycle after it is accepted.
- R9: A wrapping command whose beat count is not 2, 4, 8 or 16, or whose start address is not a multiple of the beat size, is treated like an R8 error.
- R10: While `bt_valid` is high and `bt_ready` is low, `bt_valid`, `bt_addr`, `bt_strb`, `bt_data` and `bt_last` hold their values.
- R11: `cmd_ready` is low from the acceptance of a valid command until the cycle after its last beat is taken.
- R12: After the active-low synchronous reset, `cmd_ready` is 1 and `pl_ready`, `bt_valid` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_burst | input | 2 | Burst kind: 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| cmd_size | input | 3 | Beat size code, 2^code bytes per beat |
| cmd_len | input | LEN_W | Beat count minus one |
| cmd_err | output | 1 | One-cycle pulse after an illegal command is accepted |
| pl_valid | input | 1 | Payload beat offered |
| pl_ready | output | 1 | Payload beat can be taken |
| pl_data | input | DATA_W | Payload beat, low bytes first |
| bt_valid | output | 1 | Bus beat available |
| bt_ready | input | 1 | Downstream takes the bus beat |
| bt_addr | output | ADDR_W | Bus-aligned beat address |
| bt_strb | output | DATA_W/8 | Byte strobe |
| bt_data | output | DATA_W | Payload placed in its lanes |
| bt_last | output | 1 | Final beat of the burst |

## Verification
A payload beat taken at a clock edge shows up on the output ports right after that edge. The bench therefore computes the expected address, strobe, data and last flag when the payload handshake is committed. It compares them when that beat's output handshake is committed, with the output-ready pattern stalling the stream regularly. `cmd_err` is due exactly one cycle after an illegal command is taken and is checked there; the following cycles check that it has dropped and that no beat appears. The return of `cmd_ready` is checked in the cycle after the last output handshake.

// File: rtl/blg_pkg.sv
package blg_pkg;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;
endpackage

// File: rtl/blg_cmd_check.sv
module blg_cmd_check
  import blg_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  burst_e            burst,
  input  logic [SIZE_W-1:0] size,
  input  logic [LEN_W-1:0]  len,
  output logic              ok
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] size_mask;
  logic              size_ok;
  logic              wrap_len_ok;
  logic              wrap_ok;

  always_comb begin
    size_mask   = (ADDR_W'(1) << size) - ADDR_W'(1);
    size_ok     = int'(size) <= OFF_W;
    wrap_len_ok = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                  (len == LEN_W'(7)) || (len == LEN_W'(15));
    wrap_ok     = (burst != BURST_WRAP) ||
                  (wrap_len_ok && ((addr & size_mask) == '0));
    ok          = (burst != BURST_RSVD) && size_ok && wrap_ok;
  end
endmodule

// File: rtl/blg_addr_step.sv
module blg_addr_step
  import blg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  burst_e            ld_burst,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              adv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [SIZE_W-1:0] cur_size,
  output logic              last_beat
);
  burst_e            burst_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  idx_q;
  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] step_mask;
  logic [ADDR_W-1:0] win_mask;
  logic [ADDR_W-1:0] incr_next;
  logic [ADDR_W-1:0] wrap_next;
  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    step_bytes = ADDR_W'(1) << cur_size;
    step_mask  = step_bytes - ADDR_W'(1);
    win_mask   = ((ADDR_W'(len_q) + ADDR_W'(1)) << cur_size) - ADDR_W'(1);
    incr_next  = (cur_addr & ~step_mask) + step_bytes;
    wrap_next  = (cur_addr & ~win_mask) | ((cur_addr + step_bytes) & win_mask);
    unique case (burst_q)
      BURST_INCR: next_addr = incr_next;
      BURST_WRAP: next_addr = wrap_next;
      default:    next_addr = cur_addr;
    endcase
    last_beat = (idx_q == len_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_size <= '0;
      burst_q  <= BURST_FIXED;
      len_q    <= '0;
      idx_q    <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      cur_size <= ld_size;
      burst_q  <= ld_burst;
      len_q    <= ld_len;
      idx_q    <= '0;
    end else if (adv) begin
      cur_addr <= next_addr;
      idx_q    <= idx_q + LEN_W'(1);
    end
  end

  assert_fixed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && burst_q == BURST_FIXED) |=> $stable(cur_addr));

  assert_wrap_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && burst_q == BURST_WRAP) |=>
      ((cur_addr & ~win_mask) == ($past(cur_addr) & ~win_mask)));
endmodule

// File: rtl/blg_lane_place.sv
module blg_lane_place
  import blg_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]   beat_addr,
  input  logic [SIZE_W-1:0]   size,
  input  logic [DATA_W-1:0]   payload,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] strb,
  output logic [DATA_W-1:0]   data
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam logic [OFF_W:0] ONE = (OFF_W + 1)'(1);

  logic [OFF_W:0]    nbytes;
  logic [OFF_W:0]    lo;
  logic [OFF_W:0]    base;
  logic [OFF_W:0]    hi;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    nbytes   = ONE << size;
    lo       = {1'b0, beat_addr[OFF_W-1:0]};
    base     = lo & ~(nbytes - ONE);
    hi       = base + nbytes - ONE;
    shifted  = payload << {base, 3'b000};
    bus_addr = {beat_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    localparam logic [OFF_W:0] LANE = (OFF_W + 1)'(g);
    assign strb[g]         = (LANE >= lo) && (LANE <= hi);
    assign data[8*g +: 8]  = strb[g] ? shifted[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/burst_lane_gen.sv
module burst_lane_gen
  import blg_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [1:0]          cmd_burst,
  input  logic [SIZE_W-1:0]   cmd_size,
  input  logic [LEN_W-1:0]    cmd_len,
  output logic                cmd_err,
  input  logic                pl_valid,
  output logic                pl_ready,
  input  logic [DATA_W-1:0]   pl_data,
  output logic                bt_valid,
  input  logic                bt_ready,
  output logic [ADDR_W-1:0]   bt_addr,
  output logic [DATA_W/8-1:0] bt_strb,
  output logic [DATA_W-1:0]   bt_data,
  output logic                bt_last
);
  localparam int BYTES = DATA_W / 8;

  burst_e            cmd_kind;
  logic              busy;
  logic              in_done;
  logic              cmd_ok;
  logic              cmd_fire;
  logic              pl_fire;
  logic              out_fire;
  logic              beat_last;
  logic [ADDR_W-1:0] cur_addr;
  logic [SIZE_W-1:0] cur_size;
  logic [ADDR_W-1:0] lane_addr;
  logic [BYTES-1:0]  lane_strb;
  logic [DATA_W-1:0] lane_data;

  assign cmd_kind  = burst_e'(cmd_burst);
  assign cmd_ready = !busy;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign pl_ready  = busy && !in_done && (!bt_valid || bt_ready);
  assign pl_fire   = pl_valid && pl_ready;
  assign out_fire  = bt_valid && bt_ready;

  blg_cmd_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
    .addr  (cmd_addr),
    .burst (cmd_kind),
    .size  (cmd_size),
    .len   (cmd_len),
    .ok    (cmd_ok)
  );

  blg_addr_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cmd_fire && cmd_ok),
    .ld_addr   (cmd_addr),
    .ld_burst  (cmd_kind),
    .ld_size   (cmd_size),
    .ld_len    (cmd_len),
    .adv       (pl_fire),
    .cur_addr  (cur_addr),
    .cur_size  (cur_size),
    .last_beat (beat_last)
  );

  blg_lane_place #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_place (
    .beat_addr (cur_addr),
    .size      (cur_size),
    .payload   (pl_data),
    .bus_addr  (lane_addr),
    .strb      (lane_strb),
    .data      (lane_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      in_done  <= 1'b0;
      cmd_err  <= 1'b0;
      bt_valid <= 1'b0;
      bt_addr  <= '0;
      bt_strb  <= '0;
      bt_data  <= '0;
      bt_last  <= 1'b0;
    end else begin
      cmd_err <= cmd_fire && !cmd_ok;
      if (cmd_fire && cmd_ok) begin
        busy    <= 1'b1;
        in_done <= 1'b0;
      end else if (out_fire && bt_last) begin
        busy <= 1'b0;
      end
      if (pl_fire) begin
        bt_valid <= 1'b1;
        bt_addr  <= lane_addr;
        bt_strb  <= lane_strb;
        bt_data  <= lane_data;
        bt_last  <= beat_last;
        if (beat_last) in_done <= 1'b1;
      end else if (out_fire) begin
        bt_valid <= 1'b0;
      end
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bt_valid && !bt_ready) |=> (bt_valid && $stable(bt_addr) && $stable(bt_strb) &&
                                 $stable(bt_data) && $stable(bt_last)));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid |-> !cmd_ready);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !bt_valid);

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bt_valid |-> (($countones(bt_strb) <= (1 << cur_size)) && (bt_strb != '0)));
endmodule

// File: tb/burst_lane_gen_bench.sv
module burst_lane_gen_bench;
  localparam int DW = 128;
  localparam int AW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0]    cmd_burst = '0;
  logic [2:0]    cmd_size = '0;
  logic [LW-1:0] cmd_len = '0;
  logic          cmd_err;
  logic          pl_valid = 1'b0;
  logic          pl_ready;
  logic [DW-1:0] pl_data = '0;
  logic          bt_valid;
  logic          bt_ready = 1'b0;
  logic [AW-1:0] bt_addr;
  logic [15:0]   bt_strb;
  logic [DW-1:0] bt_data;
  logic          bt_last;

  always #2.5 clk = ~clk;

  burst_lane_gen #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u_burst_lane_gen (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_burst(cmd_burst), .cmd_size(cmd_size), .cmd_len(cmd_len), .cmd_err(cmd_err),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .bt_valid(bt_valid), .bt_ready(bt_ready), .bt_addr(bt_addr),
    .bt_strb(bt_strb), .bt_data(bt_data), .bt_last(bt_last)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [AW-1:0] q_addr[$];
  logic [15:0]   q_strb[$];
  logic [DW-1:0] q_data[$];
  logic          q_last[$];
  string         q_tag[$];

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Reference: beat i of a burst, computed from the address rules alone.
  function automatic void model_beat(longint start, int burst, int size, int len, int i,
                                     logic [DW-1:0] pay, output logic [AW-1:0] a_o,
                                     output logic [15:0] s_o, output logic [DW-1:0] d_o);
    longint nb = longint'(1) << size;
    longint a, w, base;
    int lo, alo;
    case (burst)
      0: a = start;
      1: a = (i == 0) ? start : (start / nb) * nb + i * nb;
      default: begin
        w    = nb * (len + 1);
        base = (start / w) * w;
        a    = base + ((start - base) + i * nb) % w;
      end
    endcase
    a_o = AW'((a / 16) * 16);
    lo  = int'(a % 16);
    alo = lo - lo % int'(nb);
    s_o = '0;
    d_o = '0;
    for (int j = alo; j < alo + int'(nb); j++) begin
      if (j >= lo) begin
        s_o[j]       = 1'b1;
        d_o[8*j +: 8] = pay[8*(j-alo) +: 8];
      end
    end
  endfunction

  // Output monitor: drives bt_ready and compares each committed handshake.
  logic          hold_pend = 1'b0;
  logic [AW-1:0] h_addr;
  logic [15:0]   h_strb;
  logic [DW-1:0] h_data;
  logic          h_last;

  always @(negedge clk) begin
    cyc++;
    if (hold_pend) begin
      chk(bt_valid && bt_addr == h_addr && bt_strb == h_strb && bt_data == h_data &&
          bt_last == h_last, "R10 hold under stall", bt_data, h_data);
    end
    bt_ready  = (cyc % 4 != 1);
    hold_pend = bt_valid && !bt_ready;
    h_addr = bt_addr; h_strb = bt_strb; h_data = bt_data; h_last = bt_last;
    if (bt_valid && bt_ready) begin
      if (q_addr.size() == 0) begin
        chk(1'b0, "R8 unexpected beat", DW'(bt_addr), '0);
      end else begin
        chk(bt_addr == q_addr[0], $sformatf("R1/%s addr", q_tag[0]), DW'(bt_addr), DW'(q_addr[0]));
        chk(bt_strb == q_strb[0] && bt_data == q_data[0], $sformatf("R5/%s lanes", q_tag[0]),
            {bt_strb, bt_data[111:0]}, {q_strb[0], q_data[0][111:0]});
        chk(bt_data == q_data[0], $sformatf("R5/%s data", q_tag[0]), bt_data, q_data[0]);
        chk(bt_last == q_last[0], "R7 last flag", DW'(bt_last), DW'(q_last[0]));
        void'(q_addr.pop_front()); void'(q_strb.pop_front());
        void'(q_data.pop_front()); void'(q_last.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic send_cmd(logic [AW-1:0] a, int b, int s, int l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_burst = 2'(b); cmd_size = 3'(s); cmd_len = LW'(l);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_burst(logic [AW-1:0] a, int b, int s, int l, string tag);
    logic [AW-1:0] ea;
    logic [15:0]   es;
    logic [DW-1:0] ed;
    send_cmd(a, b, s, l);
    #1;
    chk(cmd_ready == 1'b0, "R11 busy after command", DW'(cmd_ready), '0);
    for (int i = 0; i <= l; i++) begin
      @(negedge clk);
      pl_valid = 1'b1;
      pl_data  = {$urandom, $urandom, $urandom, $urandom};
      #1;
      while (!pl_ready) begin @(negedge clk); #1; end
      model_beat(longint'(a), b, s, l, i, pl_data, ea, es, ed);
      q_addr.push_back(ea); q_strb.push_back(es); q_data.push_back(ed);
      q_last.push_back(i == l); q_tag.push_back(tag);
    end
    @(negedge clk);
    pl_valid = 1'b0;
    #1;
    while (q_addr.size() != 0 || bt_valid) begin @(negedge clk); #1; end
    chk(cmd_ready == 1'b1, "R11 idle after last beat", DW'(cmd_ready), DW'(1));
  endtask

  task automatic bad_cmd(logic [AW-1:0] a, int b, int s, int l, string tag);
    send_cmd(a, b, s, l);
    #1;
    chk(cmd_err == 1'b1, {tag, " error pulse"}, DW'(cmd_err), DW'(1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(cmd_err == 1'b0 && bt_valid == 1'b0 && cmd_ready == 1'b1,
          {tag, " no beats after error"}, DW'({cmd_err, bt_valid, cmd_ready}), DW'(1));
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cmd_ready == 1'b1 && pl_ready == 1'b0 && bt_valid == 1'b0 && cmd_err == 1'b0,
        "R12 reset state", DW'({cmd_ready, pl_ready, bt_valid, cmd_err}), DW'(4'b1000));

    run_burst(32'h106, 0, 0, 4, "R2");
    run_burst(32'h104, 1, 2, 3, "R3");
    run_burst(32'h704, 2, 2, 3, "R4");
    run_burst(32'h010, 1, 4, 3, "R6");
    run_burst(32'h105, 1, 2, 2, "R3");
    run_burst(32'h003, 2, 0, 7, "R4");
    run_burst(32'h20C, 1, 3, 1, "R3");

    bad_cmd(32'h100, 3, 2, 3, "R8");
    bad_cmd(32'h100, 1, 5, 0, "R8");
    bad_cmd(32'h700, 2, 2, 2, "R9");
    bad_cmd(32'h702, 2, 2, 3, "R9");
    bad_cmd(32'h700, 2, 2, 0, "R9");

    run_burst(32'h7F0, 2, 4, 1, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule